// File: doc/BRIEF.md
# Frame-locked instruction sequencer

This block walks the program counter of a stream-oriented audio DSP core. Each accepted audio frame start loads the start address and advances the counter one address per clock, so one instruction executes per cycle. When the fetched instruction carries the jump-to-start flag, the counter returns to the start address and idles until the next frame start. Branch and loop requests can load any target address while a program runs.

Every frame has a fixed cycle budget. The budget comes from a rate-select input that also picks the normal, dual or quad speed mode, or disables the start pulse entirely. Two conditions raise an overrun fault that only reset clears, and while the fault is set the block ignores frames. The first is a program that uses up its budget without jumping back to start. The second is a frame that arrives before the counter has returned. A run input enables the core, and dropping it mutes the serial outputs in the same cycle.

Top module: `frame_seq`

## Requirements
- R1: After reset `pc_o` is 0x2010, `exec_o` is low and `overrun_o` is low. Reset is the only way to clear `overrun_o`.
- R2: In the cycle after an accepted frame start, `exec_o` is high and `pc_o` is 0x2010. Without a branch or a jump, `pc_o` then rises by one each cycle.
- R3: If `jump_start_i` is high in an executing cycle, then in the next cycle `exec_o` is low and `pc_o` is 0x2010. Both stay that way until the next accepted frame start.
- R4: If `branch_i` is high in an executing cycle with no jump, then `pc_o` in the next cycle equals `branch_addr_i`, and counting continues from there.
- R5: A frame start in the same cycle as an executing jump-to-start counts as on time. Execution restarts at 0x2010 in the next cycle and no overrun is raised.
- R6: The `rate_i` encoding is 0 for normal speed (budget 3584), 1 for dual speed (1792) and 2 for quad speed (896). The value 0x1C, and any other value, disables the start pulse, so frame starts have no effect.
- R7: A frame start with `run_i` low is ignored. If `run_i` falls during execution, then in the next cycle `exec_o` is low and `pc_o` is 0x2010.
- R8: `mute_o` is high in exactly the cycles in which `run_i` is low, with no delay.
- R9: A program whose jump-to-start executes in the last cycle of its budget completes without an overrun.
- R10: If the last cycle of the budget executes without a jump-to-start, then in the next cycle `overrun_o` is high and `exec_o` is low.
- R11: An accepted frame start during execution without a jump sets `overrun_o` and stops execution. `overrun_o` then stays high, and frame starts are ignored until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_i | input | 1 | Audio frame start pulse |
| run_i | input | 1 | Core run enable |
| rate_i | input | 5 | Rate select: 0 normal, 1 dual, 2 quad, other values (0x1C) start pulse off |
| branch_i | input | 1 | Branch or loop request in the current cycle |
| branch_addr_i | input | ADDR_W | Branch target address |
| jump_start_i | input | 1 | The instruction at `pc_o` is a jump-to-start |
| pc_o | output | ADDR_W | Program address |
| exec_o | output | 1 | Instruction at `pc_o` executes this cycle |
| overrun_o | output | 1 | Sticky frame overrun fault |
| mute_o | output | 1 | Forces the serial outputs to zero |

## Verification
The hardest cases to reach are the edges of the budget. The stimulus has to keep a program running for exactly the budget count of cycles. It does this by counting executing cycles after the accepting edge and raising the jump flag only on the final one. It then repeats the frame without the flag and checks the cycle one before and the cycle at the limit. The jump that lands in the same cycle as a new frame start is driven deliberately, to show that the on-time case does not look like an overrun.

// File: rtl/frame_seq_pkg.sv
package frame_seq_pkg;
  localparam int unsigned RATE_W = 5;

  typedef enum logic [RATE_W-1:0] {
    RATE_NORM = 5'h00,
    RATE_DUAL = 5'h01,
    RATE_QUAD = 5'h02,
    RATE_OFF  = 5'h1C
  } rate_e;
endpackage

// File: rtl/fs_rate_dec.sv
module fs_rate_dec
  import frame_seq_pkg::*;
#(
  parameter int unsigned CNT_W       = 12,
  parameter int unsigned BUDGET_NORM = 3584
) (
  input  logic [RATE_W-1:0] rate_i,
  output logic              start_en_o,
  output logic [CNT_W-1:0]  budget_o
);
  localparam logic [CNT_W-1:0] BUD_N = CNT_W'(BUDGET_NORM);
  localparam logic [CNT_W-1:0] BUD_D = CNT_W'(BUDGET_NORM / 2);
  localparam logic [CNT_W-1:0] BUD_Q = CNT_W'(BUDGET_NORM / 4);

  always_comb begin
    start_en_o = 1'b1;
    budget_o   = BUD_N;
    case (rate_e'(rate_i))
      RATE_NORM: budget_o = BUD_N;
      RATE_DUAL: budget_o = BUD_D;
      RATE_QUAD: budget_o = BUD_Q;
      default:   start_en_o = 1'b0;  // includes RATE_OFF
    endcase
  end
endmodule

// File: rtl/fs_pc.sv
module fs_pc #(
  parameter int unsigned           ADDR_W     = 14,
  parameter logic [ADDR_W-1:0]     START_ADDR = 14'h2010
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              abort_i,
  input  logic              accept_i,
  input  logic              done_i,
  input  logic              branch_i,
  input  logic [ADDR_W-1:0] target_i,
  output logic [ADDR_W-1:0] pc_o,
  output logic              busy_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_o   <= START_ADDR;
      busy_o <= 1'b0;
    end else if (abort_i) begin
      pc_o   <= START_ADDR;
      busy_o <= 1'b0;
    end else if (accept_i) begin
      pc_o   <= START_ADDR;
      busy_o <= 1'b1;
    end else if (busy_o) begin
      if (done_i) begin
        pc_o   <= START_ADDR;
        busy_o <= 1'b0;
      end else if (branch_i) begin
        pc_o <= target_i;
      end else begin
        pc_o <= pc_o + 1'b1;
      end
    end
  end
endmodule

// File: rtl/fs_budget.sv
module fs_budget #(
  parameter int unsigned CNT_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             accept_i,
  input  logic             busy_i,
  input  logic             done_i,
  input  logic             late_i,
  input  logic [CNT_W-1:0] budget_i,
  output logic             err_set_o,
  output logic             fault_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] lim_q;
  logic             last_cyc;

  // budget-th executing cycle of the frame with no jump
  assign last_cyc  = busy_i && !done_i && (cnt_q == lim_q - CNT_W'(1));
  assign err_set_o = late_i || last_cyc;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      lim_q <= '1;
    end else if (accept_i) begin
      cnt_q <= '0;
      lim_q <= budget_i;
    end else if (busy_i) begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) fault_o <= 1'b0;
    else if (err_set_o) fault_o <= 1'b1;
  end
endmodule

// File: rtl/frame_seq.sv
module frame_seq
  import frame_seq_pkg::*;
#(
  parameter int unsigned       ADDR_W      = 14,
  parameter logic [ADDR_W-1:0] START_ADDR  = 14'h2010,
  parameter int unsigned       BUDGET_NORM = 3584
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frame_i,
  input  logic              run_i,
  input  logic [RATE_W-1:0] rate_i,
  input  logic              branch_i,
  input  logic [ADDR_W-1:0] branch_addr_i,
  input  logic              jump_start_i,
  output logic [ADDR_W-1:0] pc_o,
  output logic              exec_o,
  output logic              overrun_o,
  output logic              mute_o
);
  localparam int unsigned CNT_W = $clog2(BUDGET_NORM + 1);

  logic             start_en;
  logic [CNT_W-1:0] budget;
  logic             busy;
  logic             fault;
  logic             err_set;
  logic             frame_ok;
  logic             done;
  logic             accept;
  logic             late;
  logic             abort;

  assign frame_ok = frame_i && run_i && start_en && !fault;
  assign done     = busy && jump_start_i;
  assign accept   = frame_ok && (!busy || jump_start_i);
  assign late     = frame_ok && busy && !jump_start_i;
  assign abort    = !run_i || err_set;

  fs_rate_dec #(
    .CNT_W      (CNT_W),
    .BUDGET_NORM(BUDGET_NORM)
  ) i_rate_dec (
    .rate_i    (rate_i),
    .start_en_o(start_en),
    .budget_o  (budget)
  );

  fs_pc #(
    .ADDR_W    (ADDR_W),
    .START_ADDR(START_ADDR)
  ) i_pc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .abort_i (abort),
    .accept_i(accept),
    .done_i  (done),
    .branch_i(branch_i),
    .target_i(branch_addr_i),
    .pc_o    (pc_o),
    .busy_o  (busy)
  );

  fs_budget #(
    .CNT_W(CNT_W)
  ) i_budget (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .accept_i (accept),
    .busy_i   (busy),
    .done_i   (done),
    .late_i   (late),
    .budget_i (budget),
    .err_set_o(err_set),
    .fault_o  (fault)
  );

  assign exec_o    = busy;
  assign overrun_o = fault;
  assign mute_o    = !run_i;  // immediate, no register
endmodule

// File: rtl/frame_seq_chk.sv
module frame_seq_chk #(
  parameter int unsigned       ADDR_W     = 14,
  parameter logic [ADDR_W-1:0] START_ADDR = 14'h2010
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              frame_i,
  input logic              run_i,
  input logic [4:0]        rate_i,
  input logic              branch_i,
  input logic [ADDR_W-1:0] branch_addr_i,
  input logic              jump_start_i,
  input logic [ADDR_W-1:0] pc_o,
  input logic              exec_o,
  input logic              overrun_o
);
  // R1
  idle_at_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !exec_o |-> pc_o == START_ADDR);

  // R2
  pc_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exec_o && run_i && !jump_start_i && !branch_i && !frame_i
    |=> (pc_o == ADDR_W'($past(pc_o) + 1'b1)) || overrun_o);

  // R3
  jump_home_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exec_o && jump_start_i && !frame_i |=> !exec_o && pc_o == START_ADDR);

  // R4
  branch_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exec_o && run_i && branch_i && !jump_start_i && !frame_i
    |=> (pc_o == $past(branch_addr_i)) || overrun_o);

  // R6
  start_gated_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !exec_o && rate_i == 5'h1C |=> !exec_o);

  // R7
  halt_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> !exec_o);

  // R11
  fault_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overrun_o |=> overrun_o && !exec_o);
endmodule

bind frame_seq frame_seq_chk #(
  .ADDR_W    (ADDR_W),
  .START_ADDR(START_ADDR)
) i_frame_seq_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .frame_i      (frame_i),
  .run_i        (run_i),
  .rate_i       (rate_i),
  .branch_i     (branch_i),
  .branch_addr_i(branch_addr_i),
  .jump_start_i (jump_start_i),
  .pc_o         (pc_o),
  .exec_o       (exec_o),
  .overrun_o    (overrun_o)
);

// File: tb/test_frame_seq.sv
module test_frame_seq;
  localparam int unsigned ADDR_W = 14;
  localparam logic [ADDR_W-1:0] START = 14'h2010;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              frame = 1'b0;
  logic              run = 1'b0;
  logic [4:0]        rate = 5'h00;
  logic              branch = 1'b0;
  logic [ADDR_W-1:0] baddr = '0;
  logic              jump = 1'b0;
  logic [ADDR_W-1:0] pc;
  logic              exec;
  logic              ovr;
  logic              mute;

  int checks = 0;
  int fails  = 0;
  bit done_flag = 1'b0;

  always #2 clk = ~clk;

  frame_seq i_frame_seq (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .frame_i      (frame),
    .run_i        (run),
    .rate_i       (rate),
    .branch_i     (branch),
    .branch_addr_i(baddr),
    .jump_start_i (jump),
    .pc_o         (pc),
    .exec_o       (exec),
    .overrun_o    (ovr),
    .mute_o       (mute)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; frame = 0; run = 0; rate = 0; branch = 0; jump = 0;
    step();
    rst_n = 1'b1;
    step();
  endtask

  task automatic start_frame();
    frame = 1'b1;
    step();
    frame = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 pc", 32'(pc), 32'(START));
    chk("R1 exec", 32'(exec), 0);
    chk("R1 overrun", 32'(ovr), 0);
  endtask

  task automatic t_sequence();
    do_reset();
    run = 1; rate = 5'h00;
    start_frame();
    chk("R2 exec", 32'(exec), 1);
    chk("R2 first pc", 32'(pc), 32'(START));
    step();
    chk("R2 pc+1", 32'(pc), 32'(START) + 1);
    step();
    chk("R2 pc+2", 32'(pc), 32'(START) + 2);
    jump = 1;
    step();
    jump = 0;
    chk("R3 exec", 32'(exec), 0);
    chk("R3 pc", 32'(pc), 32'(START));
    repeat (3) step();
    chk("R3 idle exec", 32'(exec), 0);
    chk("R3 idle pc", 32'(pc), 32'(START));
  endtask

  task automatic t_branch();
    do_reset();
    run = 1;
    start_frame();
    branch = 1; baddr = 14'h2100;
    step();
    branch = 0;
    chk("R4 target", 32'(pc), 32'h2100);
    step();
    chk("R4 continue", 32'(pc), 32'h2101);
  endtask

  task automatic t_coincident();
    do_reset();
    run = 1;
    start_frame();
    step();
    jump = 1; frame = 1;
    step();
    jump = 0; frame = 0;
    chk("R5 exec", 32'(exec), 1);
    chk("R5 pc", 32'(pc), 32'(START));
    chk("R5 overrun", 32'(ovr), 0);
    step();
    chk("R5 pc+1", 32'(pc), 32'(START) + 1);
  endtask

  task automatic t_gating();
    do_reset();
    run = 1; rate = 5'h1C;
    start_frame();
    chk("R6 gated 0x1C", 32'(exec), 0);
    rate = 5'h07;
    start_frame();
    chk("R6 gated other", 32'(exec), 0);
    rate = 5'h00; run = 0;
    start_frame();
    chk("R7 run low ignored", 32'(exec), 0);
  endtask

  task automatic t_halt();
    do_reset();
    run = 1;
    #1;
    chk("R8 unmuted", 32'(mute), 0);
    start_frame();
    step();
    run = 0;
    #1;
    chk("R8 mute immediate", 32'(mute), 1);
    step();
    chk("R7 halted exec", 32'(exec), 0);
    chk("R7 halted pc", 32'(pc), 32'(START));
  endtask

  // Runs a frame of n cycles ending in a jump on cycle n
  task automatic t_fit(input logic [4:0] r, input int n, input string tag);
    do_reset();
    run = 1; rate = r;
    start_frame();
    for (int i = 1; i <= n; i++) begin
      jump = (i == n);
      step();
    end
    jump = 0;
    chk({tag, " overrun"}, 32'(ovr), 0);
    chk({tag, " exec"}, 32'(exec), 0);
  endtask

  task automatic t_exceed(input logic [4:0] r, input int n);
    do_reset();
    run = 1; rate = r;
    start_frame();
    for (int i = 1; i < n; i++) step();
    chk("R10 before limit", 32'(ovr), 0);
    chk("R10 still exec", 32'(exec), 1);
    step();
    chk("R10 overrun", 32'(ovr), 1);
    chk("R10 stopped", 32'(exec), 0);
  endtask

  task automatic t_late();
    do_reset();
    run = 1;
    start_frame();
    step();
    start_frame();
    chk("R11 overrun", 32'(ovr), 1);
    chk("R11 stopped", 32'(exec), 0);
    start_frame();
    chk("R11 frame ignored", 32'(exec), 0);
    chk("R11 sticky", 32'(ovr), 1);
    do_reset();
    chk("R1 cleared by reset", 32'(ovr), 0);
  endtask

  initial begin
    t_reset();
    t_sequence();
    t_branch();
    t_coincident();
    t_gating();
    t_halt();
    t_fit(5'h02, 896, "R9 quad");
    t_fit(5'h00, 3584, "R9 normal");
    t_exceed(5'h01, 1792);
    t_exceed(5'h02, 896);
    t_late();
    done_flag = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done_flag) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule